// File: doc/BRIEF.md
# Byte-to-Serial Transmit Serializer

This block turns a byte-wide transmit stream into a single-bit serial stream for one channel. It runs from a fast serial bit clock that an external synthesizer supplies. It divides that clock by the byte width to produce a parallel-rate clock, `pclk_o`. Upstream logic uses `pclk_o` so that its data keeps a fixed frequency and phase relationship with the serializer.

Data passes through two registers. A holding register samples the input byte on the rising edge of its own input clock, `piclk_i`. This clock is normally `pclk_o` wired back in, but it is a separate pin. Once every byte period, an internal load strobe copies the holding register into a parallel-loadable shift register. The strobe has a fixed phase relative to `pclk_o`. The shift register then sends the byte out most significant bit first. The serial bit leaves on two identical outputs, so that a primary and a secondary destination can both be driven.

Reset is asynchronous and active low. Each clock domain has its own two-stage release synchronizer.

Top module: `ser_tx_top`

## Requirements
- R1: `pclk_o` has a period of 8 bit clocks. It is high for 4 bit clocks and low for 4 bit clocks.
- R2: The load strobe fires for exactly one bit clock in every 8. It fires on the bit clock in which `pclk_o` falls.
- R3: The holding register samples `pin_i` on each rising edge of `piclk_i`. The shift register takes its parallel value only from the holding register.
- R4: Bit 7 of a captured byte appears on the serial outputs in the bit period right after the load. With `piclk_i` tied to `pclk_o`, that is 5 bit clocks after the rising edge of `pclk_o` that captured the byte.
- R5: Bits leave most significant first, bit 7 down to bit 0. Successive bytes follow one another with no gap and no repeated bit.
- R6: `ser_pri_o` and `ser_sec_o` carry the same value in every bit clock.
- R7: While `rst_n_i` is low, `pclk_o`, both serial outputs and both registers are low, without waiting for a clock edge.
- R8: After reset is released on a bit clock, `pclk_o` first rises on the 3rd rising bit clock edge. The holding register captures nothing on the first 2 rising edges of `piclk_i`. It first captures on the 3rd. Until the first captured byte has been loaded, the serial outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| piclk_i | input | 1 | Clock that samples the parallel input byte |
| pin_i | input | BYTE_W | Parallel input byte |
| pclk_o | output | 1 | Parallel-rate clock, bit clock divided by BYTE_W |
| ser_pri_o | output | 1 | Primary serial output |
| ser_sec_o | output | 1 | Secondary serial output, a copy of the primary |

## Verification
The bench builds the block with its default width of 8 and wires `piclk_i` back to `pclk_o`. With this setup one byte period is eight bit clocks, so every byte value can be swept through the path. Each serial bit is then predicted from its byte index and bit position.

A second pass applies reset in the middle of a run and then sends random bytes. This exercises the asynchronous clear, the offsets of the two release synchronizers, and the capture phase that lets the first byte through. The input bus is held at all ones before the first valid capture. An early capture therefore shows up as stray ones on the serial outputs.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int unsigned SER_DEF_BYTE_W   = 8;
  localparam int unsigned SER_RST_STAGES   = 2;
  localparam int unsigned SER_NUM_OUTPUTS  = 2;
endpackage

// File: rtl/ser_rst_sync.sv
`timescale 1ns/1ps
module ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

  // R7: the released reset output follows the asynchronous input low at once
  p_rst_follow_r7: assert property (@(posedge clk) !arst_n |-> !srst_n);
endmodule

// File: rtl/ser_timing_gen.sv
`timescale 1ns/1ps
module ser_timing_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic pclk_o,
  output logic load_o
);
  localparam int unsigned CW   = $clog2(DIV);
  localparam int unsigned HALF = DIV / 2;
  localparam logic [CW-1:0] LAST_CNT = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_FIRST = CW'(1);
  localparam logic [CW-1:0] HI_LAST  = CW'(HALF);
  localparam logic [CW-1:0] LOAD_AT  = CW'(HALF + 1);
  localparam int unsigned RW = CW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pclk_q, pclk_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    pclk_d = pclk_q;
    if (cnt_en) begin
      cnt_d  = (cnt_q == LAST_CNT) ? '0 : cnt_q + CW'(1);
      pclk_d = (cnt_d >= HI_FIRST) && (cnt_d <= HI_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pclk_o = pclk_q;
  assign load_o = rst_n && (cnt_q == LOAD_AT);

  // checker state: length of the current high phase of the divided clock
  logic [RW-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run_q <= '0;
    else if (pclk_q) hi_run_q <= hi_run_q + RW'(1);
    else             hi_run_q <= '0;
  end

  // R1: each high phase lasts exactly half the division ratio
  p_pclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_q) |-> (hi_run_q == RW'(HALF)));
  // R2: load fires on the cycle the divided clock falls
  p_load_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $fell(pclk_q));
  // R2: a strobe never lasts two cycles
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  // R7: divided clock held low in reset
  p_pclk_rst_r7: assert property (@(posedge clk) !rst_n |-> !pclk_o);
endmodule

// File: rtl/ser_hold_reg.sv
`timescale 1ns/1ps
module ser_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] hold_q, hold_d;
  logic         cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (cap_en) hold_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  // R3: the register holds the byte present at the previous input clock edge
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hold_q == $past(din_i)));
  // R7: cleared while reset is low
  p_hold_rst_r7: assert property (@(posedge clk) !rst_n |-> (hold_q == '0));
endmodule

// File: rtl/ser_shift_reg.sv
`timescale 1ns/1ps
module ser_shift_reg #(
  parameter int unsigned W       = 8,
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [W-1:0]       hold_i,
  output logic [NUM_OUT-1:0] ser_o
);
  logic [W-1:0]       sh_q, sh_d;
  logic [NUM_OUT-1:0] out_q;
  logic               shift_en;

  assign shift_en = 1'b1;

  always_comb begin
    sh_d = sh_q;
    if (load_i)        sh_d = hold_i;
    else if (shift_en) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[gi] <= 1'b0;
      else        out_q[gi] <= sh_d[W-1];
    end
    // R6: every copy matches the first
    p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_q[gi] == out_q[0]);
  end

  assign ser_o = out_q;

  // R4: the most significant bit of the holding register leads right after a load
  p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (out_q[0] == $past(hold_i[W-1])));
  // R5: without a load the next lower bit follows
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (out_q[0] == $past(sh_q[W-2])));
  // R7: outputs low in reset
  p_out_rst_r7: assert property (@(posedge clk) !rst_n |-> (out_q == '0));
endmodule

// File: rtl/ser_tx_top.sv
`timescale 1ns/1ps
module ser_tx_top
  import ser_pkg::*;
#(
  parameter int unsigned BYTE_W = SER_DEF_BYTE_W
) (
  input  logic              bclk_i,
  input  logic              rst_n_i,
  input  logic              piclk_i,
  input  logic [BYTE_W-1:0] pin_i,
  output logic              pclk_o,
  output logic              ser_pri_o,
  output logic              ser_sec_o
);
  localparam int unsigned NOUT = SER_NUM_OUTPUTS;

  logic              b_rst_n;
  logic              p_rst_n;
  logic              load;
  logic [BYTE_W-1:0] hold;
  logic [NOUT-1:0]   ser;

  ser_rst_sync #(.STAGES(SER_RST_STAGES)) u_bsync (
    .clk(bclk_i), .arst_n(rst_n_i), .srst_n(b_rst_n));

  ser_rst_sync #(.STAGES(SER_RST_STAGES)) u_psync (
    .clk(piclk_i), .arst_n(rst_n_i), .srst_n(p_rst_n));

  ser_timing_gen #(.DIV(BYTE_W)) u_tgen (
    .clk(bclk_i), .rst_n(b_rst_n), .pclk_o(pclk_o), .load_o(load));

  ser_hold_reg #(.W(BYTE_W)) u_hold (
    .clk(piclk_i), .rst_n(p_rst_n), .din_i(pin_i), .hold_o(hold));

  ser_shift_reg #(.W(BYTE_W), .NUM_OUT(NOUT)) u_shift (
    .clk(bclk_i), .rst_n(b_rst_n), .load_i(load), .hold_i(hold), .ser_o(ser));

  assign ser_pri_o = ser[0];
  assign ser_sec_o = ser[1];
endmodule

// File: tb/tb_ser_tx_top.sv
`timescale 1ns/1ps
module tb_ser_tx_top;
  localparam int W = 8;

  logic         bclk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = '1;
  logic         pclk, sp, ss;
  int           total = 0;
  int           bad = 0;
  logic [7:0]   seq [0:511];

  always #2.5 bclk = ~bclk;

  ser_tx_top #(.BYTE_W(W)) dut (
    .bclk_i(bclk), .rst_n_i(rst_n), .piclk_i(pclk), .pin_i(pin),
    .pclk_o(pclk), .ser_pri_o(sp), .ser_sec_o(ss));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_phase(input int n, input bit sweep);
    for (int m = 0; m < n; m++) seq[m] = sweep ? 8'(m) : 8'($urandom);
    pin = '1;
    @(negedge bclk);
    rst_n = 1'b0;
    #1;
    chk(sp == 1'b0, "R7 primary in reset", int'(sp), 0);
    chk(ss == 1'b0, "R7 secondary in reset", int'(ss), 0);
    chk(pclk == 1'b0, "R7 pclk in reset", int'(pclk), 0);
    repeat (2) @(negedge bclk);
    rst_n = 1'b1;
    for (int k = 1; k <= 24 + 8 * n + 8; k++) begin
      @(negedge bclk);
      begin
        int  ph;
        bit  exp_p, exp_s;
        int  off;
        ph    = (k - 2) % 8;
        exp_p = (k >= 3) && (ph >= 1) && (ph <= 4);
        chk(pclk == exp_p, (k < 11) ? "R8 pclk start" : "R1 pclk phase",
            int'(pclk), int'(exp_p));
        exp_s = 1'b0;
        off   = k - 24;
        if (k >= 24 && off / 8 < n) exp_s = seq[off / 8][7 - off % 8];
        if (k < 24)
          chk(sp == exp_s, "R8 idle before first load", int'(sp), int'(exp_s));
        else if (off % 8 == 0)
          chk(sp == exp_s, "R2/R4 first bit after load", int'(sp), int'(exp_s));
        else
          chk(sp == exp_s, "R3/R5 serial bit", int'(sp), int'(exp_s));
        chk(ss == sp, "R6 outputs mirror", int'(ss), int'(sp));
        if (k >= 14 && (k - 14) % 8 == 0)
          pin = ((k - 14) / 8 < n) ? seq[(k - 14) / 8] : 8'h00;
      end
    end
  endtask

  initial begin
    run_phase(256, 1'b1);
    run_phase(64, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule